// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a virtual address into a physical address in two steps. The top bits of the virtual address pick an entry in a small on-chip segment table. That entry gives the physical location of the segment's own page table and the number of pages the segment covers. The middle bits form a virtual page number, which is checked against that page count. When the page number is in range, the block reads one 32-bit page table entry from memory. It then forms the physical address from the entry's upper bits and the unchanged page offset.

A requester hands over one virtual address at a time with a valid/ready handshake. It later receives a physical address, or a fault flag, through a second valid/ready handshake. Page table entries are fetched through a memory read port that has one request outstanding at most. The segment table can only be written through a separate privileged configuration port. Reset marks every entry invalid, so all translations fault until software loads entries.

Top module: `spt_xlate`

## Requirements
- R1: The virtual address is split into three fields. The segment number is the top SEG_W bits (default 2). The virtual page number is the middle VA_W-SEG_W-OFF_W bits (default 18). The byte offset is the low OFF_W bits (default 12, a 4 KiB page).
- R2: For an in-range page, exactly one memory read is issued. Its address is the segment's page-table base plus the virtual page number shifted left by 2.
- R3: The physical address is the returned entry's bits [31:OFF_W] placed above the unchanged offset. The entry's low OFF_W bits (permission bits) have no effect on the result.
- R4: A virtual page number greater than or equal to the segment's page count gives a fault response with rsp_paddr = 0 and issues no memory read. Page count minus one still translates.
- R5: A translation through a segment entry whose valid bit is clear gives a fault response with rsp_paddr = 0 and issues no memory read.
- R6: After reset every segment entry is invalid, so any translation faults.
- R7: req_ready is high only when the block is idle. It goes low from the accepting edge until the response handshake completes, so only one translation is in flight.
- R8: While mem_req_valid is high and mem_req_ready is low, mem_req_valid stays high and mem_req_addr stays unchanged.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_paddr and rsp_fault hold their values.
- R10: A configuration write (cfg_we high) sets entry cfg_idx to cfg_valid, cfg_base and cfg_size. Translations accepted after the write use the new entry. An entry with a page count of 0 faults for every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Privileged segment table write strobe |
| cfg_idx | input | SEG_W | Segment entry to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_base | input | PA_W | Physical base of the segment's page table |
| cfg_size | input | VPN_W+1 | Number of pages in the segment |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle and able to accept |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Bounds or invalid-segment fault |
| mem_req_valid | output | 1 | Page table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Page table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry |

## Verification
The assertions check the protocol rules on every cycle. These are: the read address holds under memory backpressure, the response holds until taken, req_ready stays low while a translation is in flight, and a fault always carries a zero address. The bench scenarios cover the things a single-cycle property cannot. They compute the expected entry address and physical address for several segments and offsets, including permission bits that must be ignored. They probe the bound at page count minus one and at page count, and they count memory reads so that faults can be shown to issue none. They also cover reset and reconfiguration of the table.

// File: rtl/spt_pkg.sv
package spt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG_LOOKUP,
        ST_PTE_READ,
        ST_WAIT_DATA,
        ST_RESPOND
    } xlate_state_e;

    localparam int unsigned PTE_BYTES_LOG2 = 2;
endpackage

// File: rtl/spt_segtab.sv
module spt_segtab #(
    parameter int unsigned SEG_W = 2,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned SZ_W  = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [SZ_W-1:0]  wr_size,
    input  logic [SEG_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PA_W-1:0]  rd_base,
    output logic [SZ_W-1:0]  rd_size
);
    localparam int unsigned NSEG = 1 << SEG_W;

    logic [NSEG-1:0] valid_d, valid_q;
    logic [PA_W-1:0] base_d [NSEG];
    logic [PA_W-1:0] base_q [NSEG];
    logic [SZ_W-1:0] size_d [NSEG];
    logic [SZ_W-1:0] size_q [NSEG];

    always_comb begin
        valid_d = valid_q;
        base_d  = base_q;
        size_d  = size_q;
        if (wr_en) begin
            valid_d[wr_idx] = wr_valid;
            base_d[wr_idx]  = wr_base;
            size_d[wr_idx]  = wr_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NSEG; i++) begin
                base_q[i] <= '0;
                size_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            base_q  <= base_d;
            size_q  <= size_d;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_base  = base_q[rd_idx];
    assign rd_size  = size_q[rd_idx];
endmodule

// File: rtl/spt_addr.sv
module spt_addr #(
    parameter int unsigned VPN_W = 18,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned SZ_W  = VPN_W + 1
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic             seg_valid,
    input  logic [PA_W-1:0]  seg_base,
    input  logic [SZ_W-1:0]  seg_size,
    output logic             fault,
    output logic [PA_W-1:0]  pte_addr
);
    import spt_pkg::*;

    logic [SZ_W-1:0] vpn_ext;

    always_comb begin
        vpn_ext  = SZ_W'(vpn);
        fault    = !seg_valid || (vpn_ext >= seg_size);
        pte_addr = seg_base + (PA_W'(vpn) << PTE_BYTES_LOG2);
    end
endmodule

// File: rtl/spt_xlate.sv
module spt_xlate #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned SEG_W = 2,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned VPN_W = VA_W - SEG_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [VPN_W:0]    cfg_size,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    import spt_pkg::*;

    localparam int unsigned SZ_W  = VPN_W + 1;
    localparam int unsigned PPN_W = PA_W - OFF_W;

    typedef struct packed {
        xlate_state_e    state;
        logic [VA_W-1:0] vaddr;
        logic [PA_W-1:0] addr;
        logic [PA_W-1:0] paddr;
        logic            fault;
    } xlate_t;

    xlate_t r_d, r_q;

    logic [SEG_W-1:0] seg_idx;
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] offset;
    logic             seg_valid;
    logic [PA_W-1:0]  seg_base;
    logic [SZ_W-1:0]  seg_size;
    logic             lk_fault;
    logic [PA_W-1:0]  lk_pte_addr;

    // R1: field split of the held virtual address
    assign seg_idx = r_q.vaddr[VA_W-1 -: SEG_W];
    assign vpn     = r_q.vaddr[OFF_W +: VPN_W];
    assign offset  = r_q.vaddr[OFF_W-1:0];

    spt_segtab #(.SEG_W(SEG_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_segtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_base  (cfg_base),
        .wr_size  (cfg_size),
        .rd_idx   (seg_idx),
        .rd_valid (seg_valid),
        .rd_base  (seg_base),
        .rd_size  (seg_size)
    );

    spt_addr #(.VPN_W(VPN_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_addr (
        .vpn       (vpn),
        .seg_valid (seg_valid),
        .seg_base  (seg_base),
        .seg_size  (seg_size),
        .fault     (lk_fault),
        .pte_addr  (lk_pte_addr)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr = req_vaddr;
                    r_d.state = ST_SEG_LOOKUP;
                end
            end
            ST_SEG_LOOKUP: begin
                if (lk_fault) begin
                    r_d.fault = 1'b1;
                    r_d.paddr = '0;
                    r_d.state = ST_RESPOND;
                end else begin
                    r_d.fault = 1'b0;
                    r_d.addr  = lk_pte_addr;
                    r_d.state = ST_PTE_READ;
                end
            end
            ST_PTE_READ: begin
                if (mem_req_ready) r_d.state = ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
                if (mem_rsp_valid) begin
                    r_d.paddr = {mem_rsp_data[31 -: PPN_W], offset};
                    r_d.state = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                if (rsp_ready) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.state == ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_PTE_READ);
    assign mem_req_addr  = r_q.addr;
    assign rsp_valid     = (r_q.state == ST_RESPOND);
    assign rsp_paddr     = r_q.paddr;
    assign rsp_fault     = r_q.fault;

    AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R9
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req_valid, rsp_valid})); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R7
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0); // R4
    AST_PTE_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !$isunknown(mem_rsp_data)); // R3
endmodule

// File: tb/spt_xlate_bench.sv
module spt_xlate_bench;
    localparam int VA_W = 32, SEG_W = 2, OFF_W = 12, PA_W = 32;
    localparam int VPN_W = VA_W - SEG_W - OFF_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_valid = 1'b0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0] cfg_base = '0;
    logic [VPN_W:0] cfg_size = '0;
    logic req_valid = 1'b0, req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic rsp_valid, rsp_ready = 1'b0, rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic mem_req_valid, mem_req_ready;
    logic [PA_W-1:0] mem_req_addr;
    logic mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int tests = 0, fails = 0;
    int stall_set = 0, lat_set = 0, rsp_delay = 0;
    int st_cnt, lat_cnt, reads;
    logic pend;
    logic [PA_W-1:0] last_addr;

    always #5 clk = ~clk;

    spt_xlate u_spt_xlate (.*);

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return {a[31:12] ^ a[21:2] ^ 20'h5A5A5, 12'hF3C};
    endfunction

    assign mem_req_ready = (st_cnt >= stall_set);

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; mem_rsp_valid <= 1'b0; st_cnt <= 0; lat_cnt <= 0;
            reads <= 0; last_addr <= '0; mem_rsp_data <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && !mem_req_ready) st_cnt <= st_cnt + 1;
            if (mem_req_valid && mem_req_ready) begin
                pend <= 1'b1; lat_cnt <= lat_set; last_addr <= mem_req_addr;
                reads <= reads + 1; st_cnt <= 0;
            end else if (pend) begin
                if (lat_cnt == 0) begin
                    pend <= 1'b0; mem_rsp_valid <= 1'b1; mem_rsp_data <= memfn(last_addr);
                end else lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic v, input logic [31:0] base, input int size);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_valid = v; cfg_base = base; cfg_size = (VPN_W+1)'(size);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Run one translation, check result, memory read count and address.
    task automatic xlate(input string req, input int seg, input int vpn, input int off,
                         input logic exp_fault, input logic [31:0] base);
        logic [31:0] va, pte_a, exp_pa;
        int r0, guard;
        logic busy_ok, hold_ok;
        logic [31:0] held;
        va = {seg[SEG_W-1:0], vpn[VPN_W-1:0], off[OFF_W-1:0]};
        pte_a = base + (32'(vpn) << 2);
        exp_pa = exp_fault ? 32'h0 : {memfn(pte_a)[31:12], off[11:0]};
        @(negedge clk);
        r0 = reads;
        req_valid = 1'b1; req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1; guard = 0;
        while (!rsp_valid && guard < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk); guard++;
        end
        check({req, " R7 busy"}, {63'b0, busy_ok & ~req_ready}, 64'd1);
        check({req, " fault"}, {63'b0, rsp_fault}, {63'b0, exp_fault});
        check({req, " paddr R3"}, {32'b0, rsp_paddr}, {32'b0, exp_pa});
        hold_ok = 1'b1; held = rsp_paddr;
        for (int i = 0; i < rsp_delay; i++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_paddr !== held) hold_ok = 1'b0;
        end
        check({req, " R9 hold"}, {63'b0, hold_ok}, 64'd1);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check({req, " reads R2"}, 64'(reads - r0), exp_fault ? 64'd0 : 64'd1);
        if (!exp_fault) check({req, " pte addr R2"}, {32'b0, last_addr}, {32'b0, pte_a});
        check({req, " idle R7"}, {63'b0, req_ready}, 64'd1);
    endtask

    task automatic t_reset;
        check("R6 reset req_ready", {63'b0, req_ready}, 64'd1);
        check("R6 reset rsp_valid", {63'b0, rsp_valid}, 64'd0);
        check("R6 reset mem_req_valid", {63'b0, mem_req_valid}, 64'd0);
        xlate("R6 seg0 after reset", 0, 0, 0, 1'b1, 0);
        xlate("R6 seg2 after reset", 2, 7, 12'h123, 1'b1, 0);
    endtask

    task automatic t_basic;
        cfg(0, 1'b1, 32'h0001_0000, 16);
        cfg(1, 1'b1, 32'h0020_0400, 1);
        cfg(2, 1'b1, 32'h0030_0000, 1 << VPN_W);
        xlate("R1 seg0 vpn5", 0, 5, 12'hDEF, 1'b0, 32'h0001_0000);
        xlate("R1 seg1 vpn0", 1, 0, 12'h000, 1'b0, 32'h0020_0400);
        xlate("R3 seg2 high vpn", 2, 18'h3FFFF, 12'hFFF, 1'b0, 32'h0030_0000);
    endtask

    task automatic t_bounds;
        xlate("R4 last page", 0, 15, 12'h010, 1'b0, 32'h0001_0000);
        xlate("R4 one past", 0, 16, 12'h010, 1'b1, 32'h0001_0000);
        xlate("R4 far past", 1, 1000, 12'h7, 1'b1, 32'h0020_0400);
        xlate("R5 invalid seg3", 3, 0, 12'h1, 1'b1, 0);
    endtask

    task automatic t_backpressure;
        stall_set = 3; lat_set = 4; rsp_delay = 3;
        xlate("R8 stalled read", 0, 9, 12'hABC, 1'b0, 32'h0001_0000);
        xlate("R9 held fault", 0, 20, 12'hABC, 1'b1, 32'h0001_0000);
        stall_set = 0; lat_set = 0; rsp_delay = 0;
    endtask

    task automatic t_reload;
        cfg(1, 1'b1, 32'h0020_0400, 0);
        xlate("R10 size zero", 1, 0, 12'h5, 1'b1, 32'h0020_0400);
        cfg(1, 1'b1, 32'h0044_0000, 8);
        xlate("R10 new base", 1, 7, 12'h5, 1'b0, 32'h0044_0000);
        cfg(0, 1'b0, 32'h0001_0000, 16);
        xlate("R10 R5 cleared valid", 0, 5, 12'h5, 1'b1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bounds();
        t_backpressure();
        t_reload();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule